// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a standard-mode two-wire (I2C) slave that holds a small file of byte-wide configuration registers. Its contents drive the rest of a chip through a flat export vector. The bus lines arrive as plain inputs and are oversampled by a fast system clock. The slave only ever pulls SDA low, through an output-enable pin that an open-drain pad turns into the wire.

The first byte after the address is a command byte, and it selects one of two access styles. If bit 7 is clear, the low seven bits name a starting register and the transfer is a block transfer that carries a byte count. A command of zero is simply the block form that starts at register 0. If bit 7 is set, the low seven bits name a register for a byte or word access, which has no count. Registers are always visited in ascending order from the start.

For a read, the master writes the command, issues a repeated start, and sends the read address. In block form the slave returns the count before the data.

Top module: `i2cCfgSlave`

## Requirements
- R1: The slave acknowledges only the write byte 0xD2 and the read byte 0xD3 (7-bit address 1101001, R/W in bit 0). Any other address byte is left unacknowledged and changes no register.
- R2: Command 0x00 followed by a count byte N and then N data bytes writes the data into registers 0 to N-1.
- R3: A command M below 128 starts an indexed block write. The next byte is a count N, and data lands in registers M to M+N-1. Each of those bytes is acknowledged. A data byte beyond N is not acknowledged and is not stored.
- R4: A command M+128 writes the data bytes that follow straight into registers M and M+1, with no count byte. A third data byte is not acknowledged and is not stored.
- R5: A read after a block command M returns first the count NUM_REGS-M (0 when M is at or beyond NUM_REGS), then registers M, M+1, and so on, until the master withholds its acknowledge.
- R6: A read after a command M+128 returns register M, then M+1, with no count byte.
- R7: Register indices at or above NUM_REGS (23) are ignored on write and read back as 0x00.
- R8: A written byte reaches the register file only at the SCL fall that ends its acknowledge slot. It never changes while SCL is high.
- R9: A stop or a start condition at any bit position abandons the byte in progress, releases SDA and returns the slave to waiting for an address. A partly received data byte is not stored.
- R10: After reset every register holds RESET_VAL (0x00) and SDA is released.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus bit rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | When 1, the pad pulls SDA low |
| regFlat | output | NUM_REGS*8 | Register file, register i in bits [8i+7:8i] |

## Verification
The bench builds the slave with its default parameters: 23 registers, address 1101001, two synchronizer stages and a zero reset value. With these values the last valid index (22) and the indices just above it can be reached with short indexed transfers. Bus bits last 80 system cycles, so the synchronizer delay falls well inside each SCL phase. With that timing the bench can show that a byte commits only after its acknowledge clock, and that a stop or repeated start placed mid-byte drops it.

// File: rtl/i2cCfgPkg.sv
package i2cCfgPkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RDATA_ACK
  } busState_t;

  // strobes from control to datapath, one system cycle each
  typedef struct packed {
    logic rxShift;    // sample SDA into receive shifter
    logic latchCmd;   // take received byte as command
    logic readStart;  // rewind pointer for a read phase
    logic rxCommit;   // acknowledged byte: count or register write
    logic txLoad;     // load next outgoing byte
    logic txShift;    // present next outgoing bit
  } ctrlStrobe_t;
endpackage

// File: rtl/i2cBusSync.sv
module i2cBusSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLevel,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  localparam int S = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [S-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev, sclLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[S-2:0], sclIn};
      sdaPipe <= {sdaPipe[S-2:0], sdaIn};
      sclPrev <= sclPipe[S-1];
      sdaPrev <= sdaPipe[S-1];
    end
  end

  assign sclLevel = sclPipe[S-1];
  assign sdaLevel = sdaPipe[S-1];
  assign sclRise  = sclLevel & ~sclPrev;
  assign sclFall  = ~sclLevel & sclPrev;
  assign startDet = sclLevel & sclPrev & sdaPrev & ~sdaLevel;
  assign stopDet  = sclLevel & sclPrev & ~sdaPrev & sdaLevel;
endmodule

// File: rtl/i2cCfgCtrl.sv
module i2cCfgCtrl
  import i2cCfgPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        startDet,
  input  logic        stopDet,
  input  logic        sdaBit,
  input  logic        addrMatch,
  input  logic        rwBit,
  input  logic        rxAccept,
  input  logic        txBit,
  output ctrlStrobe_t stb,
  output logic        sdaOe
);
  busState_t state, stateNx;
  logic [3:0] bitCnt, bitCntNx;
  logic isRead, isReadNx;
  logic mAck, mAckNx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      isRead <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      state  <= stateNx;
      bitCnt <= bitCntNx;
      isRead <= isReadNx;
      mAck   <= mAckNx;
    end
  end

  always_comb begin
    stateNx  = state;
    bitCntNx = bitCnt;
    isReadNx = isRead;
    mAckNx   = mAck;
    stb      = '0;
    if (stopDet) begin
      stateNx  = ST_IDLE;
      bitCntNx = '0;
    end else if (startDet) begin
      stateNx  = ST_ADDR;
      bitCntNx = '0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (sclRise) begin
            stb.rxShift = 1'b1;
            bitCntNx    = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            bitCntNx = '0;
            if (state == ST_ADDR) begin
              if (addrMatch) begin
                stateNx       = ST_ADDR_ACK;
                isReadNx      = rwBit;
                stb.readStart = rwBit;
              end else begin
                stateNx = ST_IDLE;
              end
            end else if (state == ST_CMD) begin
              stateNx = ST_CMD_ACK;
            end else begin
              stateNx = rxAccept ? ST_WDATA_ACK : ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          if (isRead) begin
            stb.txLoad = 1'b1;
            stateNx    = ST_RDATA;
          end else begin
            stateNx = ST_CMD;
          end
        end
        ST_CMD_ACK: if (sclFall) begin
          stb.latchCmd = 1'b1;
          stateNx      = ST_WDATA;
        end
        ST_WDATA_ACK: if (sclFall) begin
          stb.rxCommit = 1'b1;
          stateNx      = ST_WDATA;
        end
        ST_RDATA: begin
          if (sclRise) begin
            bitCntNx = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              bitCntNx = '0;
              stateNx  = ST_RDATA_ACK;
            end else begin
              stb.txShift = 1'b1;
            end
          end
        end
        ST_RDATA_ACK: begin
          if (sclRise) begin
            mAckNx = ~sdaBit;
          end else if (sclFall) begin
            if (mAck) begin
              stb.txLoad = 1'b1;
              stateNx    = ST_RDATA;
            end else begin
              stateNx = ST_IDLE;
            end
          end
        end
        default: stateNx = ST_IDLE;
      endcase
    end
  end

  assign sdaOe = (state == ST_ADDR_ACK) || (state == ST_CMD_ACK) ||
                 (state == ST_WDATA_ACK) || (state == ST_RDATA && !txBit);
endmodule

// File: rtl/i2cCfgData.sv
module i2cCfgData
  import i2cCfgPkg::*;
#(
  parameter int          NUM_REGS  = 23,
  parameter logic [6:0]  DEV_ADDR  = 7'h69,
  parameter logic [7:0]  RESET_VAL = 8'h00
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sdaBit,
  input  ctrlStrobe_t           stb,
  output logic                  addrMatch,
  output logic                  rwBit,
  output logic                  rxAccept,
  output logic                  txBit,
  output logic [NUM_REGS*8-1:0] regFlat
);
  localparam int         PTR_W   = 8;
  localparam logic [7:0] NUM8    = 8'(NUM_REGS);
  localparam logic [7:0] PTR_MAX = '1;

  logic [7:0] rxSr, txSr;
  logic [PTR_W-1:0] ptr, startIdx;
  logic blockMode, countPending;
  logic [7:0] remaining;
  logic [1:0] directCnt;
  logic [7:0] regs [NUM_REGS];
  logic [7:0] readByte, countVal;
  logic regWrite;

  assign addrMatch = (rxSr[7:1] == DEV_ADDR);
  assign rwBit     = rxSr[0];
  assign txBit     = txSr[7];
  assign rxAccept  = countPending | (blockMode ? (remaining != 8'd0) : (directCnt != 2'd2));
  assign countVal  = (startIdx < NUM8) ? (NUM8 - startIdx) : 8'd0;
  assign regWrite  = stb.rxCommit & ~countPending;

  always_comb begin
    readByte = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ptr == PTR_W'(i)) readByte = regs[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSr         <= '0;
      txSr         <= '0;
      ptr          <= '0;
      startIdx     <= '0;
      blockMode    <= 1'b0;
      countPending <= 1'b0;
      remaining    <= '0;
      directCnt    <= '0;
    end else begin
      if (stb.rxShift) rxSr <= {rxSr[6:0], sdaBit};
      if (stb.latchCmd) begin
        startIdx     <= {1'b0, rxSr[6:0]};
        ptr          <= {1'b0, rxSr[6:0]};
        blockMode    <= ~rxSr[7];
        countPending <= ~rxSr[7];
        remaining    <= '0;
        directCnt    <= '0;
      end
      if (stb.readStart) begin
        ptr          <= startIdx;
        countPending <= blockMode;
      end
      if (stb.rxCommit) begin
        if (countPending) begin
          remaining    <= rxSr;
          countPending <= 1'b0;
        end else begin
          ptr <= (ptr == PTR_MAX) ? ptr : ptr + 1'b1;
          if (blockMode) remaining <= remaining - 8'd1;
          else           directCnt <= directCnt + 2'd1;
        end
      end
      if (stb.txLoad) begin
        if (countPending) begin
          txSr         <= countVal;
          countPending <= 1'b0;
        end else begin
          txSr <= readByte;
          ptr  <= (ptr == PTR_MAX) ? ptr : ptr + 1'b1;
        end
      end else if (stb.txShift) begin
        txSr <= {txSr[6:0], 1'b0};
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regs[g] <= RESET_VAL;
      else if (regWrite && ptr == PTR_W'(g)) regs[g] <= rxSr;
    end
    assign regFlat[g*8 +: 8] = regs[g];
  end
endmodule

// File: rtl/i2cCfgSlave.sv
module i2cCfgSlave
  import i2cCfgPkg::*;
#(
  parameter int         NUM_REGS    = 23,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] RESET_VAL   = 8'h00
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] regFlat
);
  logic sdaLevel, sclRise, sclFall, startDet, stopDet;
  logic addrMatch, rwBit, rxAccept, txBit;
  ctrlStrobe_t stb;

  i2cBusSync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaLevel(sdaLevel), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2cCfgCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaLevel),
    .addrMatch(addrMatch), .rwBit(rwBit), .rxAccept(rxAccept),
    .txBit(txBit), .stb(stb), .sdaOe(sdaOe)
  );

  i2cCfgData #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR), .RESET_VAL(RESET_VAL)) u_data (
    .clk(clk), .rstN(rstN), .sdaBit(sdaLevel), .stb(stb),
    .addrMatch(addrMatch), .rwBit(rwBit), .rxAccept(rxAccept),
    .txBit(txBit), .regFlat(regFlat)
  );
endmodule

// File: rtl/i2cCfgChecker.sv
module i2cCfgChecker #(
  parameter int W = 184
) (
  input logic         clk,
  input logic         rstN,
  input logic         sclIn,
  input logic         startDet,
  input logic         stopDet,
  input logic         sdaOe,
  input logic [W-1:0] regFlat
);
  // R8: register contents move only while the bus clock is low
  a_r8_commit_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regFlat) |-> !sclIn);

  // R11: drive on SDA changes only while SCL is low
  a_r11_sda_change_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  // R9: a stop condition leaves SDA released
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);

  // R9: a start condition leaves SDA released
  a_r9_start_releases: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaOe);

  // R10: SDA is released throughout reset
  always_ff @(posedge clk) begin
    if (!rstN) a_r10_reset_release: assert (!sdaOe);
  end
endmodule

bind i2cCfgSlave i2cCfgChecker #(.W(NUM_REGS*8)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .startDet(startDet),
  .stopDet(stopDet), .sdaOe(sdaOe), .regFlat(regFlat)
);

// File: tb/tb_i2cCfgSlave.sv
`timescale 1ns/1ps
module tb_i2cCfgSlave;
  localparam int NREG = 23;
  localparam int Q    = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1;
  logic benchLow = 1'b0;
  logic sdaOe;
  logic sdaLine;
  logic [NREG*8-1:0] regFlat;

  always #5 clk = ~clk;
  assign sdaLine = ~(benchLow | sdaOe);

  i2cCfgSlave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .regFlat(regFlat)
  );

  int checks = 0;
  int failures = 0;
  int r11Viol = 0;
  logic [7:0] model [NREG];

  typedef struct { logic [7:0] val; string req; } item_t;
  item_t expQ[$];
  logic [7:0] obsQ[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] regByte(input int i);
    return regFlat[i*8 +: 8];
  endfunction

  task automatic checkRegs(input string req);
    for (int i = 0; i < NREG; i++)
      check(regByte(i) == model[i], req, regByte(i), model[i]);
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (obsQ.size() > 0) begin
        logic [7:0] got;
        item_t e;
        got = obsQ.pop_front();
        if (expQ.size() == 0) begin
          check(1'b0, "R5 unexpected read byte", got, 0);
        end else begin
          e = expQ.pop_front();
          check(got == e.val, e.req, got, e.val);
        end
      end
    end
  end

  // R11 watch: SDA drive must not move with SCL high
  always @(sdaOe) if (rstN && sclIn) r11Viol++;

  task automatic waitQ;
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic busStart;
    benchLow = 1'b0; sclIn = 1'b1; waitQ;
    benchLow = 1'b1; waitQ;
    sclIn = 1'b0; waitQ;
  endtask

  task automatic busRepStart;
    benchLow = 1'b0; waitQ;
    sclIn = 1'b1; waitQ;
    benchLow = 1'b1; waitQ;
    sclIn = 1'b0; waitQ;
  endtask

  task automatic busStop;
    benchLow = 1'b1; waitQ;
    sclIn = 1'b1; waitQ;
    benchLow = 1'b0; waitQ;
  endtask

  task automatic sendBit(input logic b);
    benchLow = ~b; waitQ;
    sclIn = 1'b1; waitQ; waitQ;
    sclIn = 1'b0; waitQ;
  endtask

  task automatic ackRise(output logic ack);
    benchLow = 1'b0; waitQ;
    sclIn = 1'b1; waitQ;
    ack = ~sdaLine;
  endtask

  task automatic ackFall;
    waitQ;
    sclIn = 1'b0; waitQ;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    ackRise(ack);
    ackFall;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      benchLow = 1'b0; waitQ;
      sclIn = 1'b1; waitQ;
      b[i] = sdaLine; waitQ;
      sclIn = 1'b0; waitQ;
    end
    benchLow = giveAck; waitQ;
    sclIn = 1'b1; waitQ; waitQ;
    sclIn = 1'b0; waitQ;
    benchLow = 1'b0;
  endtask

  // driver: write transaction, expAcks data bytes are expected to be acked
  task automatic writeSeq(input logic [7:0] cmd, input logic [7:0] data[$],
                          input int expAcks, input string req);
    logic ack;
    busStart;
    sendByte(8'hD2, ack); check(ack, {req, " addr ack"}, ack, 1);
    sendByte(cmd, ack);   check(ack, {req, " cmd ack"}, ack, 1);
    foreach (data[i]) begin
      sendByte(data[i], ack);
      check(ack == (i < expAcks), {req, " data ack"}, ack, (i < expAcks));
      if (!ack) break;
    end
    busStop;
  endtask

  // driver: read transaction of n bytes; caller queued the expected bytes
  task automatic readSeq(input logic [7:0] cmd, input int n, input string req);
    logic ack;
    logic [7:0] b;
    busStart;
    sendByte(8'hD2, ack); check(ack, {req, " addr ack"}, ack, 1);
    sendByte(cmd, ack);   check(ack, {req, " cmd ack"}, ack, 1);
    busRepStart;
    sendByte(8'hD3, ack); check(ack, {req, " read addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i < n - 1, b);
      obsQ.push_back(b);
    end
    busStop;
  endtask

  task automatic expect8(input logic [7:0] v, input string req);
    item_t e;
    e.val = v; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic runTests;
    logic ack;
    logic [7:0] d[$];
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;

    // R10 reset state
    check(sdaOe == 1'b0, "R10 sda released", sdaOe, 0);
    checkRegs("R10 reset value");

    // R1 foreign address
    busStart;
    sendByte(8'hA4, ack); check(!ack, "R1 foreign address nack", ack, 0);
    sendByte(8'h80, ack); check(!ack, "R1 no cmd ack after foreign", ack, 0);
    sendByte(8'h55, ack);
    busStop;
    checkRegs("R1 no change");

    // R2 block write from register 0
    d = '{8'h03, 8'h11, 8'h22, 8'h33};
    writeSeq(8'h00, d, 4, "R2");
    model[0] = 8'h11; model[1] = 8'h22; model[2] = 8'h33;
    checkRegs("R2 block write");

    // R3 indexed block write, extra byte refused
    d = '{8'h02, 8'hAA, 8'hBB, 8'hCC};
    writeSeq(8'h05, d, 3, "R3");
    model[5] = 8'hAA; model[6] = 8'hBB;
    checkRegs("R3 indexed write");

    // R4 word write, third byte refused
    d = '{8'hC1, 8'hC2, 8'hC3};
    writeSeq(8'h80 + 8'd10, d, 2, "R4");
    model[10] = 8'hC1; model[11] = 8'hC2;
    checkRegs("R4 word write");

    // R5 block read from 0: count 23 then data
    expect8(8'd23, "R5 count at 0");
    expect8(8'h11, "R5 data0"); expect8(8'h22, "R5 data1"); expect8(8'h33, "R5 data2");
    readSeq(8'h00, 4, "R5");

    // R5 indexed block read from 5: count 18
    expect8(8'd18, "R5 count at 5");
    expect8(8'hAA, "R5 data5"); expect8(8'hBB, "R5 data6"); expect8(8'h00, "R5 data7");
    readSeq(8'h05, 4, "R5");

    // R6 byte and word reads
    expect8(8'hC2, "R6 byte read 11");
    readSeq(8'h80 + 8'd11, 1, "R6");
    expect8(8'hC1, "R6 word read lo"); expect8(8'hC2, "R6 word read hi");
    readSeq(8'h80 + 8'd10, 2, "R6");

    // R7 out-of-range index
    d = '{8'h5A};
    writeSeq(8'h80 + 8'd30, d, 1, "R7");
    checkRegs("R7 write above range ignored");
    expect8(8'h00, "R7 read above range");
    readSeq(8'h80 + 8'd30, 1, "R7");
    d = '{8'h03, 8'hE1, 8'hE2, 8'hE3};
    writeSeq(8'h15, d, 4, "R7");
    model[21] = 8'hE1; model[22] = 8'hE2;
    checkRegs("R7 write crossing end");
    expect8(8'd2, "R7 count at 21");
    expect8(8'hE1, "R7 data21"); expect8(8'hE2, "R7 data22"); expect8(8'h00, "R7 past end");
    readSeq(8'h15, 4, "R7");

    // R8 commit after the acknowledge clock
    busStart;
    sendByte(8'hD2, ack);
    sendByte(8'h83, ack);
    for (int i = 7; i >= 0; i--) sendBit(logic'(8'h77 >> i));
    ackRise(ack);
    check(ack, "R8 data ack", ack, 1);
    check(regByte(3) == 8'h00, "R8 not committed during ack high", regByte(3), 0);
    ackFall;
    check(regByte(3) == 8'h77, "R8 committed after ack fall", regByte(3), 8'h77);
    busStop;
    model[3] = 8'h77;

    // R9 stop in mid byte
    busStart;
    sendByte(8'hD2, ack);
    sendByte(8'h84, ack);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    busStop;
    check(sdaOe == 1'b0, "R9 released after stop", sdaOe, 0);
    checkRegs("R9 stop drops partial byte");

    // R9 repeated start in mid byte
    busStart;
    sendByte(8'hD2, ack);
    sendByte(8'h86, ack);
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    busRepStart;
    sendByte(8'hD2, ack); check(ack, "R9 address after restart", ack, 1);
    sendByte(8'h86, ack);
    sendByte(8'h66, ack); check(ack, "R9 data after restart", ack, 1);
    busStop;
    model[6] = 8'h66;
    checkRegs("R9 restart write");

    // let the monitor drain
    repeat (4) @(posedge clk);
    #1;
    check(expQ.size() == 0, "R5 all expected reads seen", expQ.size(), 0);
    check(r11Viol == 0, "R11 sda stable with scl high", r11Viol, 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    fork
      runTests;
      begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule